// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block receives bytes over a two-wire synchronous link made of a clock line and a data line. It can run as clock master or as clock slave. As master it drives the transfer clock from a programmable divider of the system clock. As slave it follows an external clock, which first passes through a synchronizer. Each bit is taken on a rising transfer-clock edge, most significant bit first. When eight bits have been collected, the byte moves into a one-entry receive buffer and a buffer-full flag is raised.

A host controls the block through a small register port with three locations: control, status and receive data. In master mode the clock runs without a gap from byte to byte, so the host can receive a continuous stream by reading the buffer each time it fills. A stop request lets the byte in progress finish and then parks the clock high. The same stop request, set once the bit counter shows that a byte has begun, gives a single-byte transfer. If a byte completes while the buffer is still full, the block flags an overrun and keeps the older byte.

Top module: `sync_rx_top`

## Requirements
- R1: After reset, scl_out is 1, scl_oe is 0, and the control and status registers both read 0x00.
- R2: The control register is at address 0. Its fields are: bit0 enable, bit1 master, bit2 stop request, bits 7:4 divider select d. When enable and master are both 1, scl_oe is 1 and the clock runs with a half period of 2^d system cycles. Otherwise scl_oe is 0.
- R3: A data bit is taken on each rising transfer-clock edge, most significant bit first. In master mode the bit is sda_in at the clock edge on which scl_out rises. In slave mode both scl_in and sda_in are synchronized before the rising edge is detected.
- R4: On the 8th rising edge of a byte, the byte is copied into the receive buffer (address 2) and the full flag (status bit0, address 1) is set. A read of address 2 clears the full flag.
- R5: In master mode the clock keeps running across byte boundaries. Every falling edge is 2^(d+1) cycles after the previous one, including the edge that starts the next byte.
- R6: While the stop request is 1, the master clock finishes the byte in progress, then stays high and clocks no further bits. Clearing the stop request resumes the clock.
- R7: Set master with stop at 0, wait until the bit counter is nonzero, then set stop. Exactly one byte is received.
- R8: Status bits 6:4 hold the number of rising edges received so far in the current byte. This field reads 0 at each byte boundary.
- R9: If the 8th rising edge comes while the full flag is 1, the overrun flag (status bit1) is set. The buffer keeps its old byte and the full flag stays 1.
- R10: A write to status with bit1 at 0 clears the overrun flag, but only if status has been read with overrun at 1 since the flag was set. Without such a read, the write has no effect.
- R11: If a read of the receive buffer falls in the same cycle as a byte completion, the read returns the old byte. The new byte is loaded, the full flag stays 1, and no overrun is flagged.
- R12: Clearing enable returns the bit counter to 0 and stops the clock high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| scl_in | input | 1 | External transfer clock (slave mode) |
| scl_out | output | 1 | Generated transfer clock, idles high |
| scl_oe | output | 1 | Clock output enable (master mode) |
| sda_in | input | 1 | Serial data input |

## Verification
Two events can fall in the same cycle: a host read of the receive buffer, and the completion of a byte on its 8th rising edge. The bench provokes this in slave mode. Because the synchronized edge reaches the sampler a fixed number of cycles after scl_in rises, the bench can place the read strobe on exactly the completing cycle. The result is judged at the ports: the read must return the earlier byte, and status must then show full without overrun. A following read must return the new byte.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

    localparam int DATA_W    = 8;
    localparam int CNT_W     = $clog2(DATA_W);
    localparam int DIV_SEL_W = 4;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 spare;
        logic                 stop;
        logic                 master;
        logic                 enable;
    } ctrl_t;

    typedef struct packed {
        logic fire;
        logic bit_val;
    } sample_t;

    function automatic logic [DATA_W-1:0] pack_status(
        input logic             full,
        input logic             ovr,
        input logic [CNT_W-1:0] cnt
    );
        logic [DATA_W-1:0] s;
        s           = '0;
        s[0]        = full;
        s[1]        = ovr;
        s[4 +: CNT_W] = cnt;
        return s;
    endfunction

endpackage

// File: rtl/sync_rx_clkgen.sv
module sync_rx_clkgen
    import sync_rx_pkg::*;
#(
    parameter int SEL_W  = DIV_SEL_W,
    localparam int HALF_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stop_req,
    input  logic             at_boundary,
    input  logic [SEL_W-1:0] div_sel,
    output logic             scl_o,
    output logic             rise_o
);

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] limit;
    logic              scl_q;
    logic              at_top;
    logic              park;

    assign limit  = (HALF_W'(1) << div_sel) - HALF_W'(1);
    assign at_top = (cnt_q >= limit);
    assign park   = scl_q && at_boundary && stop_req;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            scl_q <= 1'b1;
            cnt_q <= '0;
        end else if (at_top) begin
            if (!park) begin
                cnt_q <= '0;
                scl_q <= ~scl_q;
            end
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end

    assign scl_o  = scl_q;
    assign rise_o = run && at_top && !scl_q;

endmodule

// File: rtl/sync_rx_edge.sv
module sync_rx_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic bit_o
);

    logic [STAGES-1:0] scl_sync;
    logic [STAGES-1:0] sda_sync;
    logic              scl_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '0;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '0;
                end else begin
                    scl_sync <= {scl_sync[STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) scl_prev <= 1'b1;
        else     scl_prev <= scl_sync[STAGES-1];
    end

    assign rise_o = scl_sync[STAGES-1] && !scl_prev;
    assign bit_o  = sda_sync[STAGES-1];

endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
    import sync_rx_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    localparam int CW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  sample_t          smp,
    input  logic             take,
    output logic             full_o,
    output logic             ovr_o,
    output logic             complete_o,
    output logic [WIDTH-1:0] buf_o,
    output logic [CW-1:0]    cnt_o
);

    logic [WIDTH-1:0] sh_q;
    logic [WIDTH-1:0] buf_q;
    logic [CW-1:0]    cnt_q;
    logic             full_q;
    logic             last;
    logic [WIDTH-1:0] word;
    logic             complete;
    logic             blocked;

    assign last     = (cnt_q == CW'(WIDTH - 1));
    assign word     = {sh_q[WIDTH-2:0], smp.bit_val};
    assign complete = smp.fire && last;
    assign blocked  = complete && full_q && !take;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (smp.fire) begin
            sh_q  <= word;
            cnt_q <= last ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            full_q <= 1'b0;
        end else if (complete && !blocked) begin
            buf_q  <= word;
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assign full_o     = full_q;
    assign ovr_o      = blocked;
    assign complete_o = complete;
    assign buf_o      = buf_q;
    assign cnt_o      = cnt_q;

endmodule

// File: rtl/sync_rx_top.sv
module sync_rx_top
    import sync_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              scl_in,
    output logic              scl_out,
    output logic              scl_oe,
    input  logic              sda_in
);

    ctrl_t             ctrl_q;
    logic              ovr_q;
    logic              seen_q;

    logic              en_w;
    logic              run_w;
    logic              stop_w;
    logic              m_rise;
    logic              s_rise;
    logic              s_bit;
    sample_t           smp;
    logic              fire_w;
    logic              take_w;
    logic              full_w;
    logic              ovr_pulse;
    logic              complete_w;
    logic [DATA_W-1:0] buf_w;
    logic [CNT_W-1:0]  cnt_w;

    logic              wr_ctrl;
    logic              wr_stat;
    logic              rd_stat;

    assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
    assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);
    assign take_w  = reg_rd && (reg_addr == ADDR_DATA);

    assign en_w   = ctrl_q.enable;
    assign run_w  = ctrl_q.enable && ctrl_q.master;
    assign stop_w = ctrl_q.stop;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata);
    end

    // Overrun flag with read-then-write-zero clearing.
    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            seen_q <= 1'b0;
        end else if (ovr_pulse) begin
            ovr_q  <= 1'b1;
        end else if (wr_stat && !reg_wdata[1] && seen_q) begin
            ovr_q  <= 1'b0;
            seen_q <= 1'b0;
        end else if (rd_stat && ovr_q) begin
            seen_q <= 1'b1;
        end
    end

    sync_rx_clkgen #(.SEL_W(DIV_SEL_W)) u_clkgen (
        .clk         (clk),
        .rst         (rst),
        .run         (run_w),
        .stop_req    (stop_w),
        .at_boundary (cnt_w == '0),
        .div_sel     (ctrl_q.div_sel),
        .scl_o       (scl_out),
        .rise_o      (m_rise)
    );

    sync_rx_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl_in),
        .sda_i  (sda_in),
        .rise_o (s_rise),
        .bit_o  (s_bit)
    );

    assign fire_w      = run_w ? m_rise : (en_w && s_rise);
    assign smp.fire    = fire_w;
    assign smp.bit_val = run_w ? sda_in : s_bit;

    sync_rx_shift #(.WIDTH(DATA_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .clear      (!en_w),
        .smp        (smp),
        .take       (take_w),
        .full_o     (full_w),
        .ovr_o      (ovr_pulse),
        .complete_o (complete_w),
        .buf_o      (buf_w),
        .cnt_o      (cnt_w)
    );

    assign scl_oe = run_w;

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_q;
            ADDR_STAT: reg_rdata = pack_status(full_w, ovr_q, cnt_w);
            ADDR_DATA: reg_rdata = buf_w;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sync_rx_chk.sv
module sync_rx_chk
    import sync_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              run,
    input logic              enable,
    input logic              stop,
    input logic              scl_out,
    input logic              fire,
    input logic              complete,
    input logic              take,
    input logic              full,
    input logic              ovr,
    input logic [DATA_W-1:0] buf_v,
    input logic [CNT_W-1:0]  cnt
);

    a_r12_idle_high: assert property (@(posedge clk) disable iff (rst)
        !run |=> scl_out);

    a_r6_park_high: assert property (@(posedge clk) disable iff (rst)
        (run && stop && cnt == '0 && scl_out) |=> scl_out);

    a_r4_full_after_byte: assert property (@(posedge clk) disable iff (rst)
        complete |=> full);

    a_r9_keep_old_byte: assert property (@(posedge clk) disable iff (rst)
        (complete && full && !take) |=> (ovr && $stable(buf_v)));

    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (fire && !complete) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r8_count_wrap: assert property (@(posedge clk) disable iff (rst)
        complete |=> (cnt == '0));

    a_r12_count_clear: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (cnt == '0));

endmodule

bind sync_rx_top sync_rx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .run      (run_w),
    .enable   (en_w),
    .stop     (stop_w),
    .scl_out  (scl_out),
    .fire     (fire_w),
    .complete (complete_w),
    .take     (take_w),
    .full     (full_w),
    .ovr      (ovr_q),
    .buf_v    (buf_w),
    .cnt      (cnt_w)
);

// File: tb/sync_rx_top_test.sv
module sync_rx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_in = 1'b1;
    logic       scl_out;
    logic       scl_oe;
    logic       sda_in = 1'b0;

    always #4 clk = ~clk;

    sync_rx_top uut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_in    (scl_in),
        .scl_out   (scl_out),
        .scl_oe    (scl_oe),
        .sda_in    (sda_in)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Master-mode data feeder: presents the next bit after each falling scl_out.
    logic       master_feed = 1'b0;
    logic       prev_scl = 1'b1;
    logic [7:0] tx_bytes [0:7];
    int         bit_idx = 0;
    int         last_fall = -1;
    int         gap_min = 1000000;
    int         gap_max = 0;

    always @(negedge clk) begin
        if (master_feed && prev_scl && !scl_out) begin
            if (bit_idx < 64) sda_in = tx_bytes[bit_idx / 8][7 - (bit_idx % 8)];
            bit_idx = bit_idx + 1;
            if (last_fall >= 0) begin
                if (cyc - last_fall < gap_min) gap_min = cyc - last_fall;
                if (cyc - last_fall > gap_max) gap_max = cyc - last_fall;
            end
            last_fall = cyc;
        end
        prev_scl = scl_out;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_full(output bit ok);
        logic [7:0] s;
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (s[0]) begin ok = 1; break; end
        end
    endtask

    task automatic start_feed(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3);
        tx_bytes[0] = b0; tx_bytes[1] = b1; tx_bytes[2] = b2; tx_bytes[3] = b3;
        for (int i = 4; i < 8; i++) tx_bytes[i] = 8'hFF;
        bit_idx = 0; last_fall = -1; gap_min = 1000000; gap_max = 0;
        master_feed = 1'b1;
    endtask

    task automatic slave_bit(input logic b, input bit collide, output logic [7:0] cap);
        cap = 8'h00;
        @(negedge clk);
        scl_in = 1'b0; sda_in = b;
        repeat (4) @(negedge clk);
        scl_in = 1'b1;
        if (collide) begin
            @(negedge clk);
            @(negedge clk);
            reg_addr = 2'd2; reg_rd = 1'b1;
            #1 cap = reg_rdata;
            @(negedge clk);
            reg_rd = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic test_reset();
        logic [7:0] d;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "scl_out after reset", 32'(scl_out), 32'd1);
        chk("R1", "scl_oe after reset", 32'(scl_oe), 32'd0);
        rd(2'd0, d); chk("R1", "control after reset", 32'(d), 32'h00);
        rd(2'd1, d); chk("R1", "status after reset", 32'(d), 32'h00);
    endtask

    task automatic test_single_byte();
        logic [7:0] d;
        bit ok;
        start_feed(8'hA5, 8'h5A, 8'h00, 8'h00);
        wr(2'd0, 8'h03);
        for (int i = 0; i < 200; i++) begin
            rd(2'd1, d);
            if (d[6:4] != 3'd0) break;
        end
        wr(2'd0, 8'h07);
        wait_full(ok);
        chk("R7", "single byte arrived", 32'(ok), 32'd1);
        rd(2'd2, d); chk("R3", "single byte value", 32'(d), 32'hA5);
        rd(2'd1, d); chk("R4", "full cleared by data read", 32'(d), 32'h00);
        repeat (60) @(negedge clk);
        chk("R7", "bits clocked in single byte", 32'(bit_idx), 32'd8);
        chk("R7", "clock parked high", 32'(scl_out), 32'd1);
        wr(2'd0, 8'h00);
        master_feed = 1'b0;
    endtask

    task automatic test_continuous();
        logic [7:0] d;
        bit ok;
        start_feed(8'h3C, 8'hC3, 8'h81, 8'h7E);
        wr(2'd0, 8'h23);
        #1 chk("R2", "scl_oe in master", 32'(scl_oe), 32'd1);
        wait_full(ok);
        rd(2'd2, d); chk("R5", "stream byte 1", 32'(d), 32'h3C);
        wait_full(ok);
        rd(2'd2, d); chk("R5", "stream byte 2", 32'(d), 32'hC3);
        wr(2'd0, 8'h27);
        wait_full(ok);
        rd(2'd2, d); chk("R6", "last byte before stop", 32'(d), 32'h81);
        repeat (200) @(negedge clk);
        chk("R6", "bits clocked before halt", 32'(bit_idx), 32'd24);
        chk("R6", "clock held high", 32'(scl_out), 32'd1);
        rd(2'd1, d); chk("R8", "bit count at boundary", 32'(d), 32'h00);
        chk("R2", "min falling-edge spacing", 32'(gap_min), 32'd8);
        chk("R5", "max falling-edge spacing", 32'(gap_max), 32'd8);
        wr(2'd0, 8'h23);
        wait_full(ok);
        rd(2'd2, d); chk("R6", "byte after resume", 32'(d), 32'h7E);
        wr(2'd0, 8'h20);
        repeat (10) @(negedge clk);
        chk("R12", "clock high when disabled", 32'(scl_out), 32'd1);
        chk("R12", "scl_oe low when disabled", 32'(scl_oe), 32'd0);
        rd(2'd1, d); chk("R12", "bit count cleared", 32'(d), 32'h00);
        master_feed = 1'b0;
    endtask

    task automatic test_overrun();
        logic [7:0] d;
        bit ok;
        start_feed(8'h11, 8'h22, 8'h33, 8'h44);
        wr(2'd0, 8'h03);
        wait_full(ok);
        wr(2'd0, 8'h07);
        repeat (60) @(negedge clk);
        chk("R9", "bits clocked", 32'(bit_idx), 32'd16);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R10", "overrun survives write without read", 32'(d), 32'h03);
        rd(2'd2, d); chk("R9", "old byte kept", 32'(d), 32'h11);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R10", "overrun cleared after read", 32'(d), 32'h00);
        wr(2'd0, 8'h00);
        master_feed = 1'b0;
    endtask

    task automatic test_slave_collision();
        logic [7:0] d;
        logic [7:0] cap;
        logic [7:0] b1;
        logic [7:0] b2;
        b1 = 8'h96;
        b2 = 8'h4B;
        wr(2'd0, 8'h01);
        #1 chk("R2", "scl_oe in slave", 32'(scl_oe), 32'd0);
        for (int i = 0; i < 3; i++) slave_bit(b1[7 - i], 0, cap);
        rd(2'd1, d); chk("R8", "bit count mid-byte", 32'(d), 32'h30);
        for (int i = 3; i < 8; i++) slave_bit(b1[7 - i], 0, cap);
        repeat (4) @(negedge clk);
        rd(2'd1, d); chk("R4", "full after slave byte", 32'(d), 32'h01);
        for (int i = 0; i < 7; i++) slave_bit(b2[7 - i], 0, cap);
        slave_bit(b2[0], 1, cap);
        chk("R11", "colliding read returns old byte", 32'(cap), 32'h96);
        rd(2'd1, d); chk("R11", "full kept, no overrun", 32'(d), 32'h01);
        rd(2'd2, d); chk("R3", "slave byte value", 32'(d), 32'h4B);
        wr(2'd0, 8'h00);
    endtask

    initial begin
        test_reset();
        test_single_byte();
        test_continuous();
        test_overrun();
        test_slave_collision();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule